// File: doc/BRIEF.md
# Two-Wire Serial Register Bank Slave

This block is a slave on a two-wire serial bus. It takes a clock line and an open-drain data line from a host controller and gives that host write and read access to a small bank of 8-bit control registers, for settings such as volume, bass and treble. The register contents are always present as parallel buses for the logic that uses them. Both bus lines are brought into the system clock domain and are only ever treated as data, never as a clock.

A write transaction starts with a START condition. The host then sends the device address byte with its low bit set, a sub-address byte that picks a register, and one or more data bytes, and ends with STOP. The slave acknowledges each of these bytes. A read transaction sends the device address byte with its low bit clear and no sub-address. The slave then returns registers from the pointer that the last write left, moving on after every byte the host acknowledges. When the address does not match, the slave stays off the bus until the next START.

Top module: `busRegBank`

## Requirements
- R1: A START (data falling while the clock is high) begins address reception from any state, even in the middle of a byte. A STOP (data rising while the clock is high) returns the slave to idle, and bytes clocked after a STOP without a new START are neither acknowledged nor stored.
- R2: An address byte of 8'h85 (seven address bits 7'b1000010 followed by a low bit of 1, meaning write) is acknowledged: the slave holds data low through the ninth clock pulse.
- R3: An address byte of 8'h84 (low bit 0, meaning read) is acknowledged. Any other address byte gets no acknowledge, and the slave leaves the data line released until the next START.
- R4: Every byte is sent most significant bit first. The slave samples data on the rising edge of the clock.
- R5: In a write, the byte after the address is the sub-address. Its low log2(NUM_REGS) bits load the register pointer, so the value is taken modulo NUM_REGS, which is a power of two. The byte is acknowledged.
- R6: Each data byte in a write is acknowledged and stored in the register at the pointer. The pointer then advances and wraps from NUM_REGS-1 to 0, so several data bytes fill consecutive registers.
- R7: A read carries no sub-address. The first byte returned is the register at the pointer left by the last write transaction.
- R8: After each read byte the pointer advances, with the same wrap. An acknowledge from the host makes the slave send the next register. A NACK makes the slave release the data line and go idle.
- R9: After reset every register is zero, the pointer is zero and the data line is released.
- R10: The slave changes what it drives on the data line only while the clock line is low.
- R11: The register outputs change only when a write data byte completes. Read transactions and transactions to other addresses leave them unchanged. Register i appears on regFlat[8*i+7:8*i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as received |
| sdaIn | input | 1 | Bus data line as received (wired level) |
| sdaPullLow | output | 1 | 1 pulls the data line low; 0 releases it |
| regFlat | output | NUM_REGS*8 | All registers, register i at bits 8*i+7:8*i |

## Verification
The assertions assume that each bus clock phase lasts several system clocks longer than the synchronizer delay. They also assume that the host moves the data line only while the clock is low, except when it makes a START or a STOP, and that the host never issues a START or STOP while the slave is pulling data low. The stimulus holds each clock phase for twenty system clocks and changes data at the middle of the low phase. It frames START and STOP only while the line is released. Under these conditions the rule that the slave drives only while the clock is low, and the checks on the transitions to idle and to address reception, are meaningful.

// File: rtl/busRegPkg.sv
package busRegPkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } busState_e;

  // bus events seen in the system clock domain
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startEv;
    logic stopEv;
    logic sdaBit;
  } busEv_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftRx;
    logic loadPtr;
    logic writeReg;
    logic incPtr;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;

endpackage

// File: rtl/busSync.sv
module busSync
  import busRegPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclIn,
  input  logic   sdaIn,
  output busEv_t ev
);

  logic [SYNC_STAGES-1:0] sclChain;
  logic [SYNC_STAGES-1:0] sdaChain;
  logic sclPrev;
  logic sdaPrev;
  logic sclNow;
  logic sdaNow;

  // the idle bus level is high, so the chains reset to ones
  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= sclIn;
          sdaChain <= sdaIn;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= {sclChain[SYNC_STAGES-2:0], sclIn};
          sdaChain <= {sdaChain[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclNow = sclChain[SYNC_STAGES-1];
  assign sdaNow = sdaChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  always_comb begin
    ev.sclRise = sclNow & ~sclPrev;
    ev.sclFall = ~sclNow & sclPrev;
    ev.startEv = sclNow & sclPrev & sdaPrev & ~sdaNow;
    ev.stopEv  = sclNow & sclPrev & ~sdaPrev & sdaNow;
    ev.sdaBit  = sdaNow;
  end

endmodule

// File: rtl/busCtrl.sv
module busCtrl
  import busRegPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000010
) (
  input  logic      clk,
  input  logic      rstN,
  input  busEv_t    ev,
  input  logic [7:0] rxByte,
  input  logic      txMsb,
  output dpStrobe_t strobe,
  output busState_e state,
  output logic      sdaPullLow
);

  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  busState_e stateNext;
  logic [3:0] bitCnt, bitCntNext;
  logic ackSeen, ackSeenNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      ackSeen <= 1'b0;
    end else begin
      state   <= stateNext;
      bitCnt  <= bitCntNext;
      ackSeen <= ackSeenNext;
    end
  end

  always_comb begin
    stateNext   = state;
    bitCntNext  = bitCnt;
    ackSeenNext = ackSeen;
    strobe      = '0;
    if (ev.startEv) begin
      stateNext  = ST_ADDR;
      bitCntNext = '0;
    end else if (ev.stopEv) begin
      stateNext  = ST_IDLE;
      bitCntNext = '0;
    end else begin
      unique case (state)
        ST_ADDR, ST_SUB, ST_WDATA: begin
          if (ev.sclRise) begin
            strobe.shiftRx = 1'b1;
            bitCntNext     = bitCnt + 4'd1;
          end else if (ev.sclFall && bitCnt == BITS_PER_BYTE) begin
            bitCntNext = '0;
            if (state == ST_ADDR) begin
              stateNext = (rxByte[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IDLE;
            end else if (state == ST_SUB) begin
              strobe.loadPtr = 1'b1;
              stateNext      = ST_SUB_ACK;
            end else begin
              strobe.writeReg = 1'b1;
              strobe.incPtr   = 1'b1;
              stateNext       = ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (ev.sclFall) begin
            if (rxByte[0]) begin
              stateNext = ST_SUB;
            end else begin
              strobe.loadTx = 1'b1;
              stateNext     = ST_RDATA;
            end
          end
        end
        ST_SUB_ACK, ST_WDATA_ACK: begin
          if (ev.sclFall) stateNext = ST_WDATA;
        end
        ST_RDATA: begin
          if (ev.sclRise) begin
            bitCntNext = bitCnt + 4'd1;
          end else if (ev.sclFall) begin
            if (bitCnt == BITS_PER_BYTE) begin
              bitCntNext = '0;
              stateNext  = ST_RDATA_ACK;
            end else begin
              strobe.shiftTx = 1'b1;
            end
          end
        end
        ST_RDATA_ACK: begin
          if (ev.sclRise) begin
            ackSeenNext   = ~ev.sdaBit;
            strobe.incPtr = 1'b1;
          end else if (ev.sclFall) begin
            if (ackSeen) begin
              strobe.loadTx = 1'b1;
              stateNext     = ST_RDATA;
            end else begin
              stateNext = ST_IDLE;
            end
          end
        end
        default: begin
          stateNext  = ST_IDLE;
          bitCntNext = '0;
        end
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_ADDR_ACK, ST_SUB_ACK, ST_WDATA_ACK: sdaPullLow = 1'b1;
      ST_RDATA:                              sdaPullLow = ~txMsb;
      default:                               sdaPullLow = 1'b0;
    endcase
  end

endmodule

// File: rtl/busDatapath.sv
module busDatapath
  import busRegPkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int PTR_W = $clog2(NUM_REGS),
  localparam int FLAT_W = NUM_REGS * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaBit,
  input  dpStrobe_t         strobe,
  output logic [7:0]        rxByte,
  output logic              txMsb,
  output logic [FLAT_W-1:0] regFlat
);

  localparam logic [PTR_W-1:0] PTR_ONE = 1;

  logic [7:0] rxShift;
  logic [7:0] txShift;
  logic [PTR_W-1:0] ptr;
  logic [7:0] regFile [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxShift <= '0;
    else if (strobe.shiftRx) rxShift <= {rxShift[6:0], sdaBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptr <= '0;
    else if (strobe.loadPtr) ptr <= rxShift[PTR_W-1:0];
    else if (strobe.incPtr) ptr <= ptr + PTR_ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txShift <= '1;
    else if (strobe.loadTx) txShift <= regFile[ptr];
    else if (strobe.shiftTx) txShift <= {txShift[6:0], 1'b1};
  end

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regFile[i] <= '0;
        else if (strobe.writeReg && ptr == PTR_W'(i)) regFile[i] <= rxShift;
      end
      assign regFlat[i*8 +: 8] = regFile[i];
    end
  endgenerate

  assign rxByte = rxShift;
  assign txMsb  = txShift[7];

endmodule

// File: rtl/busRegBank.sv
module busRegBank
  import busRegPkg::*;
#(
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'b1000010
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaPullLow,
  output logic [NUM_REGS*8-1:0] regFlat
);

  busEv_t    busEv;
  dpStrobe_t strobe;
  busState_e ctrlState;
  logic [7:0] rxByte;
  logic      txMsb;
  logic      startEvt;
  logic      stopEvt;

  busSync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .ev    (busEv)
  );

  busCtrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ev         (busEv),
    .rxByte     (rxByte),
    .txMsb      (txMsb),
    .strobe     (strobe),
    .state      (ctrlState),
    .sdaPullLow (sdaPullLow)
  );

  busDatapath #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .sdaBit  (busEv.sdaBit),
    .strobe  (strobe),
    .rxByte  (rxByte),
    .txMsb   (txMsb),
    .regFlat (regFlat)
  );

  assign startEvt = busEv.startEv;
  assign stopEvt  = busEv.stopEv;

endmodule

// File: rtl/busRegBankChk.sv
module busRegBankChk
  import busRegPkg::*;
#(
  parameter int FLAT_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaPullLow,
  input logic [FLAT_W-1:0] regFlat,
  input logic              startEvt,
  input logic              stopEvt,
  input busState_e         ctrlState
);

  p_start_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    startEvt |=> ctrlState == ST_ADDR);

  p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    stopEvt |=> ctrlState == ST_IDLE);

  p_idle_released_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrlState == ST_IDLE |-> !sdaPullLow);

  p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !sclIn);

  p_regs_on_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regFlat) |-> (ctrlState == ST_WDATA_ACK && $past(ctrlState) == ST_WDATA));

endmodule

bind busRegBank busRegBankChk #(.FLAT_W(NUM_REGS*8)) u_busRegBankChk (
  .clk        (clk),
  .rstN       (rstN),
  .sclIn      (sclIn),
  .sdaPullLow (sdaPullLow),
  .regFlat    (regFlat),
  .startEvt   (startEvt),
  .stopEvt    (stopEvt),
  .ctrlState  (ctrlState)
);

// File: tb/busRegBank_bench.sv
module busRegBank_bench;

  localparam int NREG = 8;
  localparam int HALF = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN;
  logic sclM;
  logic mLow;
  logic sdaLine;
  logic sdaPullLow;
  logic [NREG*8-1:0] regFlat;

  assign sdaLine = ~(mLow | sdaPullLow);

  busRegBank u_busRegBank (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclM),
    .sdaIn      (sdaLine),
    .sdaPullLow (sdaPullLow),
    .regFlat    (regFlat)
  );

  string      tagQ[$];
  logic [7:0] expQ[$];
  logic [7:0] obsQ[$];
  int total = 0;
  int bad = 0;

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectVal(input string tag, input logic [7:0] v);
    tagQ.push_back(tag);
    expQ.push_back(v);
  endtask

  task automatic observe(input logic [7:0] v);
    obsQ.push_back(v);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (obsQ.size() > 0) begin
        logic [7:0] o;
        o = obsQ.pop_front();
        total++;
        if (expQ.size() == 0) begin
          bad++;
          $display("FAIL unexpected item got=%02h exp=none", o);
        end else begin
          string t;
          logic [7:0] e;
          t = tagQ.pop_front();
          e = expQ.pop_front();
          if (o !== e) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", t, o, e);
          end
        end
      end
    end
  end

  task automatic busStart;
    mLow = 1'b0;
    waitClk(HALF);
    sclM = 1'b1;
    waitClk(HALF);
    mLow = 1'b1;
    waitClk(HALF);
    sclM = 1'b0;
    waitClk(HALF / 2);
  endtask

  task automatic busStop;
    mLow = 1'b1;
    waitClk(HALF / 2);
    sclM = 1'b1;
    waitClk(HALF);
    mLow = 1'b0;
    waitClk(HALF);
  endtask

  task automatic clockBit(input logic drvLow, output logic seen);
    mLow = drvLow;
    waitClk(HALF / 2);
    sclM = 1'b1;
    waitClk(HALF / 2);
    seen = sdaLine;
    waitClk(HALF / 2);
    sclM = 1'b0;
    waitClk(HALF / 2);
  endtask

  // expLine: 0 = acknowledged, 1 = not acknowledged
  task automatic writeByte(input string tag, input logic [7:0] b, input logic expLine);
    logic s;
    if (sclM) begin
      sclM = 1'b0;
      waitClk(HALF / 2);
    end
    for (int i = 7; i >= 0; i--) clockBit(~b[i], s);
    expectVal(tag, {7'b0, expLine});
    clockBit(1'b0, s);
    observe({7'b0, s});
  endtask

  task automatic readByte(input string tag, input logic [7:0] expByte, input logic ackIt);
    logic s;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b0, s);
      got[i] = s;
    end
    expectVal(tag, expByte);
    observe(got);
    clockBit(ackIt, s);
  endtask

  task automatic checkReg(input string tag, input int idx, input logic [7:0] v);
    expectVal(tag, v);
    observe(regFlat[idx*8 +: 8]);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic s;
    rstN = 1'b0;
    sclM = 1'b1;
    mLow = 1'b0;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);

    // R9 reset state
    for (int i = 0; i < NREG; i++) checkReg("R9 reset register", i, 8'h00);
    expectVal("R9 data released", 8'h00);
    observe({7'b0, sdaPullLow});

    // R2 R5 R6 R4 single write
    busStart();
    writeByte("R2 write address ack", 8'h85, 1'b0);
    writeByte("R5 sub-address ack", 8'h02, 1'b0);
    writeByte("R6 data ack", 8'h5A, 1'b0);
    busStop();
    checkReg("R4 R6 reg2 stored msb first", 2, 8'h5A);
    checkReg("R11 reg1 untouched", 1, 8'h00);

    // R6 burst write with wrap
    busStart();
    writeByte("R2 write address ack", 8'h85, 1'b0);
    writeByte("R5 sub-address ack", 8'h06, 1'b0);
    writeByte("R6 burst byte0 ack", 8'h11, 1'b0);
    writeByte("R6 burst byte1 ack", 8'h22, 1'b0);
    writeByte("R6 burst byte2 ack", 8'h33, 1'b0);
    busStop();
    checkReg("R6 reg6", 6, 8'h11);
    checkReg("R6 reg7", 7, 8'h22);
    checkReg("R6 wrap reg0", 0, 8'h33);

    // R7 R8 read from pointer left by write (pointer = 1)
    busStart();
    writeByte("R3 read address ack", 8'h84, 1'b0);
    readByte("R7 first read reg1", 8'h00, 1'b1);
    readByte("R8 ack advances reg2", 8'h5A, 1'b1);
    readByte("R8 ack advances reg3", 8'h00, 1'b0);
    waitClk(2);
    expectVal("R8 nack releases line", 8'h00);
    observe({7'b0, sdaPullLow});
    busStop();

    // R5 sub-address modulo, then R7 read and R8 wrap
    busStart();
    writeByte("R2 write address ack", 8'h85, 1'b0);
    writeByte("R5 sub-address 0x0F ack", 8'h0F, 1'b0);
    busStop();
    busStart();
    writeByte("R3 read address ack", 8'h84, 1'b0);
    readByte("R5 R7 pointer 7 read", 8'h22, 1'b1);
    readByte("R8 wrap read reg0", 8'h33, 1'b1);
    readByte("R8 read reg1", 8'h00, 1'b0);
    busStop();

    // R3 R11 non-matching address
    busStart();
    writeByte("R3 wrong address nack", 8'hA5, 1'b1);
    writeByte("R3 stays off bus", 8'h00, 1'b1);
    writeByte("R3 stays off bus", 8'h07, 1'b1);
    busStop();
    checkReg("R11 reg0 unchanged", 0, 8'h33);
    checkReg("R11 reg7 unchanged", 7, 8'h22);
    busStart();
    writeByte("R3 address 0x05 nack", 8'h05, 1'b1);
    busStop();

    // R1 repeated START in the middle of a byte
    busStart();
    writeByte("R2 write address ack", 8'h85, 1'b0);
    writeByte("R5 sub-address ack", 8'h03, 1'b0);
    clockBit(1'b0, s);
    clockBit(1'b1, s);
    clockBit(1'b0, s);
    clockBit(1'b1, s);
    busStart();
    writeByte("R1 address after restart ack", 8'h85, 1'b0);
    writeByte("R1 sub-address ack", 8'h04, 1'b0);
    writeByte("R1 data ack", 8'h77, 1'b0);
    busStop();
    checkReg("R1 reg4 written", 4, 8'h77);
    checkReg("R1 reg3 aborted byte not stored", 3, 8'h00);

    // R1 bytes after STOP without START are ignored
    writeByte("R1 no start nack", 8'h85, 1'b1);
    writeByte("R1 no start nack", 8'h04, 1'b1);
    writeByte("R1 no start nack", 8'hEE, 1'b1);
    busStop();
    checkReg("R1 reg4 unchanged", 4, 8'h77);

    waitClk(10);
    if (expQ.size() != 0) begin
      bad++;
      $display("FAIL scoreboard leftover got=%0d exp=0", expQ.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule